// File: doc/BRIEF.md
# Register-mapped SHA-256 block hasher

This block hashes messages with SHA-256 behind a small word-addressed register port. Software picks a transfer width (one, two or four bytes per write) and whether bus words are byte-swapped. It arms the engine with a start command, then streams exactly 64 bytes into a data register. Those bytes are gathered into sixteen 32-bit message words. When the last byte lands, the engine runs the 64 compression rounds, one per clock. It then adds the result into the running hash state in one extra cycle. The eight 32-bit hash words can be read at any time. They hold a finished digest only while the sum-valid flag is high.

Padding and length encoding belong to software, which must supply complete padded blocks. Longer messages are hashed by streaming further blocks once the engine is ready again. The hash state carries over from one block to the next. Writing data while the engine is busy drops that data and raises a sticky error. Clearing the error also rearms the engine, so the message must be hashed again from its beginning.

Top module: `sha2_hash_engine`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x1A: byte swap on, width 32-bit, ready high, sum-valid low, error low. The hash words read the eight SHA-256 initial values.
- R2: Control/status layout: bit 0 start, bit 1 byte swap, bits 3:2 width (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), bit 4 ready, bit 5 sum-valid, bit 6 error. A write of width code 3 leaves the width unchanged, and every other control write updates both swap and width.
- R3: Writing 1 to bit 0 reloads the initial hash values, discards any partial block and aborts any compression in progress. After it, ready is high and sum-valid is low. Bit 0 always reads 0.
- R4: A block takes 64, 32 or 16 data writes (address 1) at width 1, 2 or 4 bytes. Data is taken from the low bytes of the write word. Ready stays high until the write carrying the 64th byte, and is low after it.
- R5: After the completing write, ready stays low for 65 cycles. Ready and sum-valid are then high, and the hash state equals the SHA-256 compression of the block applied to the previous state.
- R6: Bytes fill each 32-bit word in arrival order, starting at bit 7:0. With swap on, the completed word is byte-reversed before use, so the first byte becomes the most significant. With swap off, it is used as assembled.
- R7: Sum-valid drops on the first accepted data write of a block.
- R8: A data write while ready is low is discarded, so the block being hashed is unchanged, and it sets the error bit. The error bit stays set until it is cleared.
- R9: A control write with bit 6 set clears the error and rearms the engine exactly as a start does.
- R10: Consecutive blocks chain: each block starts from the hash state left by the previous block.
- R11: Hash word i (H0 first) reads at address 8+i. The hash words do not change while ready is high, except on a start or error clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The checker assumes one register access per cycle. It also assumes the transfer width is not changed partway through a block: a width change mid-word would leave a partially filled word whose lane arithmetic the checks do not model. The bench only reconfigures right after a start or error clear. It finishes every block at one width. Except in the deliberate busy-write case, it writes data only after reading ready high.

// File: rtl/sha2_pkg.sv
package sha2_pkg;

  localparam int WORD_W    = 32;
  localparam int N_ROUNDS  = 64;
  localparam int WIN_DEPTH = 16;
  localparam int N_HASH    = 8;

  typedef logic [N_HASH-1:0][WORD_W-1:0] hash_t;

  typedef enum logic [1:0] {
    XFER_B8  = 2'd0,
    XFER_B16 = 2'd1,
    XFER_B32 = 2'd2
  } xfer_t;

  function automatic logic [31:0] rotr32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] bsig0(input logic [31:0] x);
    return rotr32(x, 2) ^ rotr32(x, 13) ^ rotr32(x, 22);
  endfunction

  function automatic logic [31:0] bsig1(input logic [31:0] x);
    return rotr32(x, 6) ^ rotr32(x, 11) ^ rotr32(x, 25);
  endfunction

  function automatic logic [31:0] ssig0(input logic [31:0] x);
    return rotr32(x, 7) ^ rotr32(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] ssig1(input logic [31:0] x);
    return rotr32(x, 17) ^ rotr32(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [31:0] choose(input logic [31:0] e, f, g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [31:0] majority(input logic [31:0] a, b, c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] init_hash(input int i);
    case (i)
      0: return 32'h6a09e667;
      1: return 32'hbb67ae85;
      2: return 32'h3c6ef372;
      3: return 32'ha54ff53a;
      4: return 32'h510e527f;
      5: return 32'h9b05688c;
      6: return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction

  function automatic logic [31:0] round_k(input logic [5:0] t);
    case (t)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction

  // One compression round on working variables (index 0 = a ... 7 = h).
  function automatic hash_t sha_round(input hash_t v, input logic [31:0] w,
                                      input logic [31:0] k);
    hash_t n;
    logic [31:0] t1, t2;
    t1 = v[7] + bsig1(v[4]) + choose(v[4], v[5], v[6]) + k + w;
    t2 = bsig0(v[0]) + majority(v[0], v[1], v[2]);
    n[0] = t1 + t2;
    n[1] = v[0];
    n[2] = v[1];
    n[3] = v[2];
    n[4] = v[3] + t1;
    n[5] = v[4];
    n[6] = v[5];
    n[7] = v[6];
    return n;
  endfunction

endpackage

// File: rtl/sha2_packer.sv
module sha2_packer
  import sha2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        take,
  input  xfer_t       size,
  input  logic        swap_en,
  input  logic [31:0] din,
  output logic        word_vld,
  output logic [31:0] word
);

  logic [1:0]  lane_q;
  logic [31:0] acc_q;
  logic [31:0] merged;
  logic [2:0]  nbytes;
  logic [2:0]  end_lane;
  logic        complete;

  always_comb begin
    merged = acc_q;
    nbytes = 3'd4;
    case (size)
      XFER_B8: begin
        merged[{lane_q, 3'b000} +: 8] = din[7:0];
        nbytes = 3'd1;
      end
      XFER_B16: begin
        if (lane_q[1]) merged[31:16] = din[15:0];
        else           merged[15:0]  = din[15:0];
        nbytes = 3'd2;
      end
      default: begin
        merged = din;
        nbytes = 3'd4;
      end
    endcase
    end_lane = {1'b0, lane_q} + nbytes;
    complete = end_lane[2];
  end

  assign word_vld = take && complete;
  assign word     = swap_en ? bswap32(merged) : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (flush) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      if (complete) begin
        lane_q <= '0;
        acc_q  <= '0;
      end else begin
        lane_q <= end_lane[1:0];
        acc_q  <= merged;
      end
    end
  end

endmodule

// File: rtl/sha2_msg_window.sv
module sha2_msg_window
  import sha2_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic        step,
  output logic [31:0] w_now
);

  logic [31:0] win [DEPTH];
  logic [31:0] sched_next;
  logic [31:0] fill;
  logic        shift;

  assign sched_next = ssig1(win[DEPTH-2]) + win[DEPTH-7] + ssig0(win[1]) + win[0];
  assign fill       = load ? load_word : sched_next;
  assign shift      = load || step;
  assign w_now      = win[0];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      if (gi == DEPTH - 1) begin : g_top
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     win[gi] <= '0;
          else if (shift) win[gi] <= fill;
        end
      end else begin : g_mid
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     win[gi] <= '0;
          else if (shift) win[gi] <= win[gi+1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sha2_compress.sv
module sha2_compress
  import sha2_pkg::*;
#(
  parameter int ROUNDS = N_ROUNDS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        launch,
  input  logic [31:0] w_in,
  output logic        step,
  output logic        done,
  output logic        busy,
  output hash_t       digest
);

  localparam int RW = $clog2(ROUNDS);

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_FIN} cstate_t;

  cstate_t       state_q;
  logic [RW-1:0] rnd_q;
  hash_t         hash_q;
  hash_t         vars_q;
  hash_t         vars_next;

  assign vars_next = sha_round(vars_q, w_in, round_k(6'(rnd_q)));
  assign step      = (state_q == C_RUN);
  assign done      = (state_q == C_FIN);
  assign busy      = (state_q != C_IDLE);
  assign digest    = hash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= C_IDLE;
      rnd_q   <= '0;
      vars_q  <= '0;
    end else if (init) begin
      state_q <= C_IDLE;
      rnd_q   <= '0;
    end else begin
      case (state_q)
        C_IDLE: if (launch) begin
          vars_q  <= hash_q;
          rnd_q   <= '0;
          state_q <= C_RUN;
        end
        C_RUN: begin
          vars_q <= vars_next;
          rnd_q  <= rnd_q + 1'b1;
          if (rnd_q == RW'(ROUNDS - 1)) state_q <= C_FIN;
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  genvar hi;
  generate
    for (hi = 0; hi < N_HASH; hi++) begin : g_hash
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hash_q[hi] <= init_hash(hi);
        else if (init) hash_q[hi] <= init_hash(hi);
        else if (done) hash_q[hi] <= hash_q[hi] + vars_q[hi];
      end
    end
  endgenerate

endmodule

// File: rtl/sha2_hash_engine.sv
module sha2_hash_engine
  import sha2_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DIGEST_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam logic [ADDR_W-1:0] A_CSR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIG  = ADDR_W'(DIGEST_BASE);
  localparam int WCW = $clog2(WIN_DEPTH);

  logic           swap_q;
  xfer_t          size_q;
  logic           err_q;
  logic           sumv_q;
  logic [WCW-1:0] wcnt_q;

  // named internal events
  logic csr_wr, dat_wr, start_evt, errclr_evt, restart;
  logic ready, accept, bad_wr, launch;
  logic word_vld, step, done, busy;
  logic [31:0] word, w_now;
  hash_t digest;

  assign csr_wr     = reg_valid && reg_write && (reg_addr == A_CSR);
  assign dat_wr     = reg_valid && reg_write && (reg_addr == A_DATA);
  assign start_evt  = csr_wr && reg_wdata[0];
  assign errclr_evt = csr_wr && reg_wdata[6];
  assign restart    = start_evt || errclr_evt;
  assign ready      = !busy;
  assign accept     = dat_wr && ready;
  assign bad_wr     = dat_wr && busy;
  assign launch     = word_vld && (wcnt_q == WCW'(WIN_DEPTH - 1));

  sha2_packer u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (restart),
    .take     (accept),
    .size     (size_q),
    .swap_en  (swap_q),
    .din      (reg_wdata),
    .word_vld (word_vld),
    .word     (word)
  );

  sha2_msg_window #(.DEPTH(WIN_DEPTH)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (word_vld),
    .load_word (word),
    .step      (step),
    .w_now     (w_now)
  );

  sha2_compress #(.ROUNDS(N_ROUNDS)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (restart),
    .launch (launch),
    .w_in   (w_now),
    .step   (step),
    .done   (done),
    .busy   (busy),
    .digest (digest)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= 1'b1;
      size_q <= XFER_B32;
      err_q  <= 1'b0;
      sumv_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      if (csr_wr) begin
        swap_q <= reg_wdata[1];
        if (reg_wdata[3:2] != 2'd3) size_q <= xfer_t'(reg_wdata[3:2]);
      end
      if (errclr_evt)  err_q <= 1'b0;
      else if (bad_wr) err_q <= 1'b1;
      if (restart)     sumv_q <= 1'b0;
      else if (done)   sumv_q <= 1'b1;
      else if (accept) sumv_q <= 1'b0;
      if (restart)       wcnt_q <= '0;
      else if (word_vld) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CSR)
      reg_rdata = {25'd0, err_q, sumv_q, ready, size_q, swap_q, 1'b0};
    else if (reg_addr[ADDR_W-1:3] == A_DIG[ADDR_W-1:3])
      reg_rdata = digest[reg_addr[2:0]];
  end

endmodule

// File: rtl/sha2_hash_checker.sv
module sha2_hash_checker
  import sha2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ready,
  input logic              sumv,
  input logic              err,
  input hash_t             digest
);

  localparam int BUSY_LEN = N_ROUNDS + 1;

  logic wr_csr, wr_dat, p_start, p_clr, p_restart, p_accept;
  logic [7:0] busy_cnt;

  assign wr_csr    = reg_valid && reg_write && (reg_addr == ADDR_W'(0));
  assign wr_dat    = reg_valid && reg_write && (reg_addr == ADDR_W'(1));
  assign p_start   = wr_csr && reg_wdata[0];
  assign p_clr     = wr_csr && reg_wdata[6];
  assign p_restart = p_start || p_clr;
  assign p_accept  = wr_dat && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (p_restart) busy_cnt <= '0;
    else if (!ready)    busy_cnt <= busy_cnt + 1'b1;
    else                busy_cnt <= '0;
  end

  a_r8_err_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !ready && !p_clr) |=> err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !p_clr) |=> err);

  a_r9_clear_drops_err: assert property (@(posedge clk) disable iff (!rst_n)
    p_clr |=> (!err && ready && !sumv));

  a_r3_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |=> (ready && !sumv));

  a_r4_ready_falls_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(p_accept));

  a_r7_sumv_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sumv && p_accept && !p_restart) |=> !sumv);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(p_restart)) |-> (busy_cnt == 8'(BUSY_LEN)));

  a_r5_sumv_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sumv) |-> $past(!ready));

  a_r11_digest_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !p_restart) |=> $stable(digest));

endmodule

bind sha2_hash_engine sha2_hash_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ready     (ready),
  .sumv      (sumv_q),
  .err       (err_q),
  .digest    (digest)
);

// File: tb/tb_sha2_hash_engine.sv
`timescale 1ns/1ps
module tb_sha2_hash_engine;

  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_valid = 1'b0;
  logic          reg_write = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  sha2_hash_engine #(.ADDR_W(AW), .DIGEST_BASE(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // ---------------- reference model ----------------
  localparam logic [31:0] TB_K [64] = '{
    32'h428a2f98,32'h71374491,32'hb5c0fbcf,32'he9b5dba5,32'h3956c25b,32'h59f111f1,32'h923f82a4,32'hab1c5ed5,
    32'hd807aa98,32'h12835b01,32'h243185be,32'h550c7dc3,32'h72be5d74,32'h80deb1fe,32'h9bdc06a7,32'hc19bf174,
    32'he49b69c1,32'hefbe4786,32'h0fc19dc6,32'h240ca1cc,32'h2de92c6f,32'h4a7484aa,32'h5cb0a9dc,32'h76f988da,
    32'h983e5152,32'ha831c66d,32'hb00327c8,32'hbf597fc7,32'hc6e00bf3,32'hd5a79147,32'h06ca6351,32'h14292967,
    32'h27b70a85,32'h2e1b2138,32'h4d2c6dfc,32'h53380d13,32'h650a7354,32'h766a0abb,32'h81c2c92e,32'h92722c85,
    32'ha2bfe8a1,32'ha81a664b,32'hc24b8b70,32'hc76c51a3,32'hd192e819,32'hd6990624,32'hf40e3585,32'h106aa070,
    32'h19a4c116,32'h1e376c08,32'h2748774c,32'h34b0bcb5,32'h391c0cb3,32'h4ed8aa4a,32'h5b9cca4f,32'h682e6ff3,
    32'h748f82ee,32'h78a5636f,32'h84c87814,32'h8cc70208,32'h90befffa,32'ha4506ceb,32'hbef9a3f7,32'hc67178f2};

  localparam logic [255:0] TB_IV = {32'h6a09e667,32'hbb67ae85,32'h3c6ef372,32'ha54ff53a,
                                    32'h510e527f,32'h9b05688c,32'h1f83d9ab,32'h5be0cd19};

  localparam logic [511:0] BLK_ABC = {32'h61626380, 416'd0, 32'h00000000, 32'h00000018};
  localparam logic [255:0] DIG_ABC = {32'hba7816bf,32'h8f01cfea,32'h414140de,32'h5dae2223,
                                      32'hb00361a3,32'h96177a9c,32'hb410ff61,32'hf20015ad};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [255:0] model(input logic [255:0] h, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2, s0, s1;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = m[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = w[t-16] + s0 + w[t-7] + s1;
    end
    for (int i = 0; i < 8; i++) v[i] = h[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) +
           ((v[4] & v[5]) | (~v[4] & v[6])) + TB_K[t] + w[t];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) +
           ((v[0] & v[1]) | (v[2] & (v[0] | v[1])));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = h[255 - 32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [511:0] make_block(input logic [31:0] seed);
    logic [511:0] b;
    logic [31:0] x;
    x = seed;
    for (int t = 0; t < 16; t++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      b[511 - 32*t -: 32] = x;
    end
    return b;
  endfunction

  // ---------------- checks and bus ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg_word(input int sz, input bit sw);
    return (32'(sz) << 2) | (32'(sw) << 1);
  endfunction

  // driver: streams one block; checks R4 ready edges and R7 sum-valid drop
  task automatic send_block(input logic [511:0] m, input int sz, input bit sw);
    logic [31:0] L, v;
    int nw, k;
    nw = (sz == 0) ? 4 : (sz == 1) ? 2 : 1;
    k = 0;
    for (int t = 0; t < 16; t++) begin
      L = sw ? {m[511-32*t-24 -: 8], m[511-32*t-16 -: 8], m[511-32*t-8 -: 8], m[511-32*t -: 8]}
             : m[511 - 32*t -: 32];
      for (int p = 0; p < nw; p++) begin
        if (k == 16*nw - 1) begin
          bus_rd(0, v);
          chk("R4 ready before last write", 32'(v[4]), 32'd1);
        end
        if (sz == 0)      bus_wr(1, {24'd0, L[8*p +: 8]});
        else if (sz == 1) bus_wr(1, {16'd0, L[16*p +: 16]});
        else              bus_wr(1, L);
        if (k == 0) begin
          bus_rd(0, v);
          chk("R7 sum-valid low after first write", 32'(v[5]), 32'd0);
        end
        k++;
      end
    end
    bus_rd(0, v);
    chk("R4 ready low after last write", 32'(v[4]), 32'd0);
  endtask

  task automatic push_expect(input logic [255:0] h);
    for (int i = 0; i < 8; i++) exp_q.push_back(h[255 - 32*i -: 32]);
  endtask

  task automatic wait_ready(output int n);
    logic [31:0] v;
    n = 0;
    bus_rd(0, v);
    while (!v[4] && n < 1000) begin
      @(negedge clk);
      n++;
      bus_rd(0, v);
    end
  endtask

  // monitor: waits for sum-valid, pops and compares the hash words
  task automatic monitor_drain(input string tag);
    logic [31:0] v, e;
    int n;
    n = 0;
    bus_rd(0, v);
    while (!v[5] && n < 1000) begin
      @(negedge clk); n++; bus_rd(0, v);
    end
    chk({tag, " sum-valid"}, 32'(v[5]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      if (exp_q.size() == 0) begin
        chk({tag, " scoreboard empty"}, 32'd0, 32'd1);
      end else begin
        e = exp_q.pop_front();
        bus_rd(AW'(8 + i), v);
        chk({tag, " R11 hash word"}, v, e);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [255:0] h1;
    logic [511:0] bx, b1, b2;
    int n;
    bx = make_block(32'h1badcafe);
    b1 = make_block(32'h00c0ffee);
    b2 = make_block(32'h7e57da7a);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(0, v);
    chk("R1 reset csr", v, 32'h0000001A);
    for (int i = 0; i < 8; i++) begin
      bus_rd(AW'(8 + i), v);
      chk("R1 R11 initial hash", v, TB_IV[255 - 32*i -: 32]);
    end

    // R3 start, R5 known answer at 32-bit width with swap
    bus_wr(0, cfg_word(2, 1) | 32'h1);
    bus_rd(0, v);
    chk("R3 start self-clears, rearmed", v, 32'h0000001A);
    push_expect(DIG_ABC);
    send_block(BLK_ABC, 2, 1);
    wait_ready(n);
    chk("R5 busy cycles", 32'(n), 32'd65);
    monitor_drain("R5 abc 32-bit");
    bus_rd(0, v);
    chk("R5 csr after digest", v, 32'h0000003A);

    // R4 R6 byte-wide writes
    bus_wr(0, cfg_word(0, 1) | 32'h1);
    push_expect(DIG_ABC);
    send_block(BLK_ABC, 0, 1);
    wait_ready(n);
    monitor_drain("R4 R6 abc 8-bit");

    // R6 halfword writes, swap off
    bus_wr(0, cfg_word(1, 0) | 32'h1);
    push_expect(model(TB_IV, bx));
    send_block(bx, 1, 0);
    wait_ready(n);
    monitor_drain("R6 16-bit no swap");

    // R10 chaining
    bus_wr(0, cfg_word(2, 1) | 32'h1);
    h1 = model(TB_IV, b1);
    push_expect(h1);
    send_block(b1, 2, 1);
    wait_ready(n);
    monitor_drain("R10 first block");
    push_expect(model(h1, b2));
    send_block(b2, 2, 1);
    wait_ready(n);
    monitor_drain("R10 second block");

    // R8 write while busy is dropped, error is sticky
    bus_wr(0, cfg_word(2, 1) | 32'h1);
    push_expect(model(TB_IV, bx));
    send_block(bx, 2, 1);
    bus_wr(1, 32'hdeadbeef);
    bus_rd(0, v);
    chk("R8 error set by busy write", 32'(v[6]), 32'd1);
    wait_ready(n);
    monitor_drain("R8 block unaffected");
    bus_rd(0, v);
    chk("R8 error sticky", 32'(v[6]), 32'd1);

    // R9 error clear rearms
    bus_wr(0, cfg_word(2, 1) | 32'h40);
    bus_rd(0, v);
    chk("R9 csr after clear", v, 32'h0000001A);
    bus_rd(8, v);
    chk("R9 hash reloaded", v, 32'h6a09e667);
    push_expect(DIG_ABC);
    send_block(BLK_ABC, 2, 1);
    wait_ready(n);
    monitor_drain("R9 fresh hash after clear");

    // R2 illegal width ignored; legal write updates swap and width
    bus_wr(0, cfg_word(3, 1));
    bus_rd(0, v);
    chk("R2 width code 3 ignored", v & 32'h0E, 32'h0A);
    bus_wr(0, cfg_word(0, 0));
    bus_rd(0, v);
    chk("R2 width and swap updated", v & 32'h0F, 32'h00);
    bus_rd(8, v);
    chk("R11 hash stable across config", v, DIG_ABC[255:224]);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule